// File: doc/BRIEF.md
# Linked-List DMA Control Block Walker

This block follows a chain of control blocks in memory on behalf of one frame-DMA channel. Each control block sits on a 64-bit boundary. Its first word links to the following block. Its second word gives the data-block length and an end-of-frame flag. After that come a status word and a pointer word for each data block. The number of data blocks per control block is set for the channel when it starts. For each data block the walker fetches the pointer and offers it, with the length, to a data mover. It waits until the mover reports how many bytes it used, then writes a status word back into the control block.

Software starts the channel with the address of the first control block. The walk ends when it reads a link word with bit 0 set, which no aligned address can have. The channel then parks and raises a refill interrupt. Software can add more blocks to a parked list by rewriting that link word and pulsing a reload strobe. A valid link that points back into the list makes the walker cycle forever until software stops it. A frame interrupt marks each control block whose end-of-frame flag was set. Channels marked for extraction also check that each data block is aligned and that its length is a multiple of 128 bytes.

Top module: `dcb_walker`

## Requirements
- R1: After reset the walker is idle: `ch_busy`, `ch_err`, `mem_req`, `blk_valid`, `irq_frame` and `irq_refill` are all low.
- R2: A start address whose bits [2:0] are not all zero is refused. `ch_err` goes high, no memory request is made and the walker stays idle. A later valid start clears `ch_err`.
- R3: For a control block at byte address D, the walker reads D (link) first and then D+8 (info). For data block i it reads the pointer at D+24+16*i and writes the status at D+16+16*i, in that order. Every request address is 8-byte aligned. No new request is raised while a read awaits `mem_rvalid`.
- R4: The walker offers each data block with `blk_addr` equal to the fetched pointer and `blk_len` equal to info bits [15:0]. The offer is held stable until `blk_ready` is seen.
- R5: After `mv_done`, the status write carries bit 63 set and `mv_bytes` in bits [15:0]. All other bits are zero.
- R6: The number of data blocks handled per control block is `ch_nblk`, sampled at start. A value of 0 is treated as 1, and a value above MAX_BLK is treated as MAX_BLK.
- R7: `irq_frame` pulses for one cycle after the last status write of a control block whose info bit 16 is set. There is no pulse when that bit is clear.
- R8: A link word with bit 0 set parks the channel. `irq_refill` pulses once, `ch_busy` goes low, and no memory traffic follows while parked.
- R9: A valid link that points to an earlier block, including the same block, is followed, so the walker revisits it without end.
- R10: A link word with bit 0 clear and bits [2:1] not zero sets `ch_err` and returns to idle with no `irq_refill`.
- R11: When `ch_extract` was set at start, a pointer whose bits [2:0] are not zero, or a length whose bits [6:0] are not zero, sets `ch_err`. The walker then goes idle without offering the block or writing its status. Without `ch_extract` such blocks are offered.
- R12: A `ch_reload` pulse while parked re-reads the link word of the last control block and follows it. The blocks of that last control block are not offered again.
- R13: `ch_stop` while busy takes effect once the current control block is finished, with no further memory read. While parked it returns the walker to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_start | input | 1 | Start pulse, taken while idle |
| ch_start_ptr | input | AW | Byte address of the first control block |
| ch_nblk | input | NW | Data blocks per control block |
| ch_extract | input | 1 | Extraction channel: enables block checks |
| ch_stop | input | 1 | Stop pulse |
| ch_reload | input | 1 | Reload pulse, taken while parked |
| ch_busy | output | 1 | Walker is working through the list |
| ch_err | output | 1 | Last start or walk ended on a rule violation |
| irq_frame | output | 1 | One-cycle frame-complete pulse |
| irq_refill | output | 1 | One-cycle list-exhausted pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | 64 | Write data (status word) |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| blk_valid | output | 1 | Data block offered to the mover |
| blk_ready | input | 1 | Mover accepts the block |
| blk_addr | output | AW | Data block address |
| blk_len | output | LW | Data block length in bytes |
| mv_done | input | 1 | Mover finished the block |
| mv_bytes | input | LW | Bytes the mover used |

## Verification
The block-count setting is swept over every value from 0 to 5 on a two-block chain. Comparing the full access trace against one computed from the address arithmetic shows whether clamping, the order of words within a block and the status offsets are right. Read latency and mover stall vary from access to access, so a walker that runs ahead of a response or drops a held offer produces a different trace. Separate chains cover self-linking, misaligned links, parked reload and extraction rule violations. Each one ends the walk in a different way, so the tests can tell apart the walker parking, halting on an error, stopping at a block boundary or carrying on.

// File: rtl/dcbw_pkg.sv
package dcbw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_NEXT, ST_INFO, ST_PTR, ST_OFFER,
    ST_MOVE, ST_STAT, ST_EVAL, ST_PARK, ST_RELINK
  } walk_st_e;

  localparam int INFO_EOF_BIT  = 16;
  localparam int STAT_DONE_BIT = 63;
endpackage

// File: rtl/dcbw_addr.sv
// Word address generator for the control-block fields.
module dcbw_addr import dcbw_pkg::*; #(
  parameter int AW = 64,
  parameter int IW = 2
) (
  input  walk_st_e        st,
  input  logic [AW-1:0]   base,
  input  logic [IW-1:0]   idx,
  output logic [AW-1:0]   addr
);
  logic [AW-1:0] pair_off;

  always_comb begin
    pair_off = AW'(idx) << 4;
    case (st)
      ST_INFO: addr = base + AW'(8);
      ST_PTR:  addr = base + AW'(24) + pair_off;
      ST_STAT: addr = base + AW'(16) + pair_off;
      default: addr = base;
    endcase
  end
endmodule

// File: rtl/dcbw_chk.sv
// Alignment and length rules for link, start and data-block words.
module dcbw_chk (
  input  logic       extract,
  input  logic [2:0] start_lo,
  input  logic [2:0] link_lo,
  input  logic [2:0] ptr_lo,
  input  logic [6:0] len_lo,
  output logic       start_bad,
  output logic       link_end,
  output logic       link_bad,
  output logic       blk_bad
);
  always_comb begin
    start_bad = (start_lo != 3'b000);
    link_end  = link_lo[0];
    link_bad  = !link_lo[0] && (link_lo[2:1] != 2'b00);
    blk_bad   = extract && ((ptr_lo != 3'b000) || (len_lo != 7'd0));
  end
endmodule

// File: rtl/dcbw_blkcnt.sv
// Per-channel block count (clamped) and current block index.
module dcbw_blkcnt #(
  parameter int MAX_BLK = 4,
  parameter int NW      = 3,
  parameter int IW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NW-1:0] cfg,
  input  logic          clr,
  input  logic          inc,
  output logic [IW-1:0] idx,
  output logic          last
);
  logic [NW-1:0] nblk_q, nblk_c;
  logic [IW-1:0] idx_n;

  always_comb begin
    if (cfg == '0)                   nblk_c = NW'(1);
    else if (cfg > NW'(MAX_BLK))     nblk_c = NW'(MAX_BLK);
    else                             nblk_c = cfg;
    idx_n = idx;
    if (clr)      idx_n = '0;
    else if (inc) idx_n = idx + 1'b1;
    last = (NW'(idx) == nblk_q - NW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nblk_q <= NW'(1);
      idx    <= '0;
    end else begin
      if (load)        nblk_q <= nblk_c;
      if (clr || inc)  idx    <= idx_n;
    end
  end
endmodule

// File: rtl/dcb_walker.sv
module dcb_walker import dcbw_pkg::*; #(
  parameter int AW      = 64,
  parameter int LW      = 16,
  parameter int MAX_BLK = 4,
  localparam int NW     = $clog2(MAX_BLK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_start,
  input  logic [AW-1:0] ch_start_ptr,
  input  logic [NW-1:0] ch_nblk,
  input  logic          ch_extract,
  input  logic          ch_stop,
  input  logic          ch_reload,
  output logic          ch_busy,
  output logic          ch_err,
  output logic          irq_frame,
  output logic          irq_refill,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata,
  output logic          blk_valid,
  input  logic          blk_ready,
  output logic [AW-1:0] blk_addr,
  output logic [LW-1:0] blk_len,
  input  logic          mv_done,
  input  logic [LW-1:0] mv_bytes
);
  localparam int IW = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  walk_st_e      st, st_n;
  logic [AW-1:0] cur, cur_n, link, link_n, bptr, bptr_n;
  logic [LW-1:0] len_q, len_n, used, used_n;
  logic          eof_q, eof_n, err_q, err_n, stop_q, stop_n, ext_q, ext_n;
  logic          iss_q, iss_n, irqf_n, irqr_n, irqf_q, irqr_q;
  logic          cfg_load, idx_clr, idx_inc, idx_last, rd_st, rd_done;
  logic          start_bad, link_end, link_bad, blk_bad;
  logic [IW-1:0] idx;

  dcbw_addr #(.AW(AW), .IW(IW)) u_addr (
    .st(st), .base(cur), .idx(idx), .addr(mem_addr));

  dcbw_chk u_chk_rules (
    .extract(ext_q), .start_lo(ch_start_ptr[2:0]), .link_lo(link[2:0]),
    .ptr_lo(mem_rdata[2:0]), .len_lo(len_q[6:0]),
    .start_bad(start_bad), .link_end(link_end), .link_bad(link_bad),
    .blk_bad(blk_bad));

  dcbw_blkcnt #(.MAX_BLK(MAX_BLK), .NW(NW), .IW(IW)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .load(cfg_load), .cfg(ch_nblk),
    .clr(idx_clr), .inc(idx_inc), .idx(idx), .last(idx_last));

  assign rd_st   = (st == ST_NEXT) || (st == ST_INFO) || (st == ST_PTR) || (st == ST_RELINK);
  assign rd_done = iss_q && mem_rvalid;
  assign ch_busy = (st != ST_IDLE) && (st != ST_PARK);

  always_comb begin
    st_n = st;  cur_n = cur;  link_n = link;  bptr_n = bptr;
    len_n = len_q;  eof_n = eof_q;  used_n = used;  err_n = err_q;
    ext_n = ext_q;  stop_n = stop_q || (ch_stop && ch_busy);
    irqf_n = 1'b0;  irqr_n = 1'b0;
    cfg_load = 1'b0;  idx_clr = 1'b0;  idx_inc = 1'b0;
    case (st)
      ST_IDLE: begin
        stop_n = 1'b0;
        if (ch_start) begin
          if (start_bad) err_n = 1'b1;
          else begin
            err_n = 1'b0;  cur_n = ch_start_ptr;  ext_n = ch_extract;
            cfg_load = 1'b1;  st_n = ST_NEXT;
          end
        end
      end
      ST_NEXT: if (rd_done) begin link_n = mem_rdata[AW-1:0]; st_n = ST_INFO; end
      ST_INFO: if (rd_done) begin
        len_n = mem_rdata[LW-1:0];  eof_n = mem_rdata[INFO_EOF_BIT];
        idx_clr = 1'b1;  st_n = ST_PTR;
      end
      ST_PTR: if (rd_done) begin
        bptr_n = mem_rdata[AW-1:0];
        if (blk_bad) begin err_n = 1'b1; st_n = ST_IDLE; end
        else st_n = ST_OFFER;
      end
      ST_OFFER: if (blk_ready) st_n = ST_MOVE;
      ST_MOVE:  if (mv_done) begin used_n = mv_bytes; st_n = ST_STAT; end
      ST_STAT: if (mem_gnt) begin
        if (idx_last) begin irqf_n = eof_q; st_n = ST_EVAL; end
        else begin idx_inc = 1'b1; st_n = ST_PTR; end
      end
      ST_EVAL: begin
        if (stop_q || ch_stop)  st_n = ST_IDLE;
        else if (link_end)      begin irqr_n = 1'b1; st_n = ST_PARK; end
        else if (link_bad)      begin err_n = 1'b1; st_n = ST_IDLE; end
        else                    begin cur_n = link; st_n = ST_NEXT; end
      end
      ST_PARK: begin
        stop_n = 1'b0;
        if (ch_stop)        st_n = ST_IDLE;
        else if (ch_reload) st_n = ST_RELINK;
      end
      ST_RELINK: if (rd_done) begin link_n = mem_rdata[AW-1:0]; st_n = ST_EVAL; end
      default: st_n = ST_IDLE;
    endcase
    iss_n = iss_q;
    if (mem_req && mem_gnt && !mem_we) iss_n = 1'b1;
    else if (rd_done)                  iss_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st <= ST_IDLE;  cur <= '0;  link <= '0;  bptr <= '0;
      len_q <= '0;  eof_q <= 1'b0;  used <= '0;  err_q <= 1'b0;
      ext_q <= 1'b0;  stop_q <= 1'b0;  iss_q <= 1'b0;
      irqf_q <= 1'b0;  irqr_q <= 1'b0;
    end else begin
      st <= st_n;  cur <= cur_n;  link <= link_n;  bptr <= bptr_n;
      len_q <= len_n;  eof_q <= eof_n;  used <= used_n;  err_q <= err_n;
      ext_q <= ext_n;  stop_q <= stop_n;  iss_q <= iss_n;
      irqf_q <= irqf_n;  irqr_q <= irqr_n;
    end
  end

  always_comb begin
    mem_wdata = '0;
    mem_wdata[LW-1:0] = used;
    mem_wdata[STAT_DONE_BIT] = 1'b1;
  end

  assign mem_req    = (rd_st && !iss_q) || (st == ST_STAT);
  assign mem_we     = (st == ST_STAT);
  assign blk_valid  = (st == ST_OFFER);
  assign blk_addr   = bptr;
  assign blk_len    = len_q;
  assign ch_err     = err_q;
  assign irq_frame  = irqf_q;
  assign irq_refill = irqr_q;
endmodule

// File: rtl/dcbw_walker_chk.sv
module dcbw_walker_chk #(
  parameter int AW = 64,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic          mem_rvalid,
  input logic [2:0]    addr_lo,
  input logic          wdata_done,
  input logic          blk_valid,
  input logic          blk_ready,
  input logic [AW-1:0] blk_addr,
  input logic [LW-1:0] blk_len,
  input logic          ch_busy,
  input logic          ch_err,
  input logic          irq_frame,
  input logic          irq_refill
);
  logic rd_out;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rd_out <= 1'b0;
    else if (mem_req && mem_gnt && !mem_we) rd_out <= 1'b1;
    else if (mem_rvalid)                 rd_out <= 1'b0;
  end

  p_one_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out |-> !mem_req);
  p_word_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (addr_lo == 3'b000));
  p_offer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_addr) && $stable(blk_len)));
  p_status_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> wdata_done);
  p_frame_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_frame |=> !irq_frame);
  p_park_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_refill |-> (!ch_busy && !mem_req));
  p_err_no_offer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ch_err |-> !blk_valid);
endmodule

bind dcb_walker dcbw_walker_chk #(.AW(AW), .LW(LW)) u_walker_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .addr_lo(mem_addr[2:0]),
  .wdata_done(mem_wdata[63]), .blk_valid(blk_valid), .blk_ready(blk_ready),
  .blk_addr(blk_addr), .blk_len(blk_len), .ch_busy(ch_busy), .ch_err(ch_err),
  .irq_frame(irq_frame), .irq_refill(irq_refill));

// File: tb/tb_dcb_walker.sv
`timescale 1ns/1ps
module tb_dcb_walker;
  localparam int AW = 64;
  localparam int LW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ch_start, ch_extract, ch_stop, ch_reload;
  logic [AW-1:0] ch_start_ptr;
  logic [2:0] ch_nblk;
  logic ch_busy, ch_err, irq_frame, irq_refill;
  logic mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic blk_valid, blk_ready, mv_done;
  logic [AW-1:0] blk_addr;
  logic [LW-1:0] blk_len, mv_bytes;

  dcb_walker dut (.*);

  assign mem_gnt = 1'b1;

  logic [63:0] m [0:63];
  logic [63:0] tr_a [0:255]; logic tr_w [0:255]; logic [63:0] tr_d [0:255];
  logic [63:0] ex_a [0:255]; logic ex_w [0:255]; logic [63:0] ex_d [0:255];
  logic [63:0] of_a [0:63];  logic [15:0] of_l [0:63];
  logic [63:0] eo_a [0:63];  logic [15:0] eo_l [0:63];
  int tr_n, ex_n, of_n, eo_n, ek, cnt_f, cnt_r, n_chk, n_bad;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory responder: read latency 1..3 cycles, writes land at once
  initial begin
    bit rd_pend; int rd_wait; int lat; logic [5:0] rd_idx;
    rd_pend = 0; rd_wait = 0; lat = 0; rd_idx = '0;
    mem_rvalid = 0; mem_rdata = '0;
    forever @(negedge clk) begin
      mem_rvalid = 0;
      if (rd_pend) begin
        if (rd_wait == 0) begin mem_rvalid = 1; mem_rdata = m[rd_idx]; rd_pend = 0; end
        else rd_wait--;
      end
      if (mem_req) begin
        if (tr_n < 256) begin tr_a[tr_n] = mem_addr; tr_w[tr_n] = mem_we; tr_d[tr_n] = mem_wdata; end
        tr_n++;
        if (mem_we) m[mem_addr[8:3]] = mem_wdata;
        else begin rd_pend = 1; rd_idx = mem_addr[8:3]; rd_wait = lat; lat = (lat + 1) % 3; end
      end
    end
  end

  // data mover: stalls, accepts, reports bytes = len - (offer index mod 5)
  initial begin
    bit got; int mv_cnt; int stall;
    got = 0; mv_cnt = 0; stall = 0;
    blk_ready = 0; mv_done = 0; mv_bytes = '0;
    forever @(negedge clk) begin
      blk_ready = 0; mv_done = 0;
      if (blk_valid && !got) begin
        if (stall > 0) stall--;
        else begin
          blk_ready = 1; got = 1;
          if (of_n < 64) begin of_a[of_n] = blk_addr; of_l[of_n] = blk_len; end
          mv_bytes = blk_len - 16'(of_n % 5);
          of_n++; mv_cnt = 2;
        end
      end else if (mv_cnt > 0) begin
        mv_cnt--;
        if (mv_cnt == 0) begin mv_done = 1; got = 0; stall = of_n % 3; end
      end
    end
  end

  initial forever @(negedge clk) begin
    if (irq_frame) cnt_f++;
    if (irq_refill) cnt_r++;
  end

  function automatic logic [63:0] bp(input int base, input int i);
    return 64'h1000 + 64'(base * 4) + 64'(i * 64);
  endfunction

  task automatic put_dcb(input int base, input logic [63:0] nxt, input int len, input bit eof);
    m[base/8] = nxt;
    m[base/8 + 1] = 64'(len) | (64'(eof) << 16);
    for (int i = 0; i < 4; i++) begin
      m[base/8 + 2 + 2*i] = '0;
      m[base/8 + 3 + 2*i] = bp(base, i);
    end
  endtask

  task automatic add_ex(input logic [63:0] a, input bit w, input logic [63:0] d);
    ex_a[ex_n] = a; ex_w[ex_n] = w; ex_d[ex_n] = d; ex_n++;
  endtask

  task automatic add_of(input logic [63:0] a, input int len);
    eo_a[eo_n] = a; eo_l[eo_n] = 16'(len); eo_n++;
    add_ex(0, 0, 0); ex_n--; // keeps ex arrays untouched
  endtask

  task automatic exp_blk(input int base, input int i, input logic [63:0] ptr, input int len);
    add_ex(64'(base + 24 + 16*i), 0, 0);
    eo_a[eo_n] = ptr; eo_l[eo_n] = 16'(len); eo_n++;
    add_ex(64'(base + 16 + 16*i), 1, 64'h8000_0000_0000_0000 | 64'(16'(len) - 16'(ek % 5)));
    ek++;
  endtask

  task automatic exp_dcb(input int base, input int e, input int len);
    add_ex(64'(base), 0, 0);
    add_ex(64'(base + 8), 0, 0);
    for (int i = 0; i < e; i++) exp_blk(base, i, bp(base, i), len);
  endtask

  task automatic clear_logs();
    tr_n = 0; ex_n = 0; of_n = 0; eo_n = 0; ek = 0; cnt_f = 0; cnt_r = 0;
  endtask

  task automatic compare(input string tag);
    chk(tr_n == ex_n, {tag, " access count"}, 64'(tr_n), 64'(ex_n));
    for (int i = 0; i < ex_n && i < tr_n; i++) begin
      chk(tr_a[i] == ex_a[i], {tag, " address"}, tr_a[i], ex_a[i]);
      chk(tr_w[i] == ex_w[i], {tag, " direction"}, 64'(tr_w[i]), 64'(ex_w[i]));
      if (ex_w[i]) chk(tr_d[i] == ex_d[i], {tag, " R5 status word"}, tr_d[i], ex_d[i]);
    end
    chk(of_n == eo_n, {tag, " R4 offer count"}, 64'(of_n), 64'(eo_n));
    for (int i = 0; i < eo_n && i < of_n; i++) begin
      chk(of_a[i] == eo_a[i], {tag, " R4 offer address"}, of_a[i], eo_a[i]);
      chk(of_l[i] == eo_l[i], {tag, " R4 offer length"}, 64'(of_l[i]), 64'(eo_l[i]));
    end
  endtask

  task automatic pulse_stop();
    @(negedge clk); ch_stop = 1; @(negedge clk); ch_stop = 0;
  endtask

  task automatic start(input logic [63:0] ptr, input int nb, input bit ext);
    pulse_stop();
    @(negedge clk);
    ch_start = 1; ch_start_ptr = ptr; ch_nblk = 3'(nb); ch_extract = ext;
    @(negedge clk); ch_start = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (ch_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired, act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    for (int i = 0; i < 64; i++) m[i] = '0;
    clear_logs();
    rst_n = 0; ch_start = 0; ch_stop = 0; ch_reload = 0; ch_extract = 0;
    ch_start_ptr = '0; ch_nblk = 3'd1;
    repeat (4) @(negedge clk);
    chk(!ch_busy && !ch_err && !mem_req && !blk_valid && !irq_frame && !irq_refill,
        "R1 reset outputs", {58'd0, ch_busy, ch_err, mem_req, blk_valid, irq_frame, irq_refill}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!ch_busy && !mem_req, "R1 idle after release", 64'(ch_busy), 0);

    // R2: misaligned start addresses
    for (int off = 1; off < 8; off++) begin
      clear_logs();
      start(64'(off), 1, 0);
      repeat (6) @(negedge clk);
      chk(ch_err == 1'b1, "R2 error flag", 64'(ch_err), 1);
      chk(tr_n == 0 && !ch_busy, "R2 no traffic", 64'(tr_n), 0);
    end

    // R3 R6 R7 R8: block count sweep on a two-block chain
    for (int n = 0; n < 6; n++) begin
      int e;
      int lena;
      e = (n == 0) ? 1 : (n > 4 ? 4 : n);
      lena = 16'h100 + n * 16'h80;
      clear_logs();
      put_dcb(0, 64'h80, lena, 0);
      put_dcb(16'h80, 64'h1, 16'h180, 1);
      exp_dcb(0, e, lena);
      exp_dcb(16'h80, e, 16'h180);
      start(64'h0, n, 0);
      wait_idle();
      compare("R3 R6 sweep");
      chk(cnt_f == 1, "R7 frame pulses", 64'(cnt_f), 1);
      chk(cnt_r == 1, "R8 refill pulses", 64'(cnt_r), 1);
      chk(ch_err == 0, "R2 error cleared by valid start", 64'(ch_err), 0);
    end

    // R12: parked after the last sweep (4 blocks); append a block and reload
    clear_logs();
    repeat (10) @(negedge clk);
    chk(tr_n == 0, "R8 parked and quiet", 64'(tr_n), 0);
    m[16'h80 / 8] = 64'h100;
    put_dcb(16'h100, 64'h1, 16'h200, 1);
    add_ex(64'h80, 0, 0);
    exp_dcb(16'h100, 4, 16'h200);
    @(negedge clk); ch_reload = 1; @(negedge clk); ch_reload = 0;
    wait_idle();
    compare("R12 reload");
    chk(cnt_f == 1 && cnt_r == 1, "R12 interrupts after reload", 64'(cnt_f), 1);

    // R9 R13: self-linked block runs until stopped
    begin
      int at;
      clear_logs();
      put_dcb(0, 64'h0, 16'h100, 1);
      start(64'h0, 1, 0);
      while (of_n < 6) @(negedge clk);
      @(negedge clk); ch_stop = 1; at = of_n; @(negedge clk); ch_stop = 0;
      wait_idle();
      repeat (20) @(negedge clk);
      chk(of_n - at <= 1, "R13 stop at block boundary", 64'(of_n - at), 1);
      chk(tr_w[tr_n - 1] == 1'b1, "R13 no read after stop", 64'(tr_w[tr_n - 1]), 1);
      chk(!ch_busy, "R13 idle after stop", 64'(ch_busy), 0);
      for (int i = 0; i < of_n; i++)
        chk(of_a[i] == bp(0, 0), "R9 same block revisited", of_a[i], bp(0, 0));
      chk(cnt_f == of_n, "R9 R7 one frame pulse per pass", 64'(cnt_f), 64'(of_n));
      chk(cnt_r == 0, "R9 no refill", 64'(cnt_r), 0);
    end

    // R10: misaligned link
    clear_logs();
    put_dcb(0, 64'h84, 16'h100, 1);
    exp_dcb(0, 1, 16'h100);
    start(64'h0, 1, 0);
    wait_idle();
    compare("R10 bad link");
    chk(ch_err == 1, "R10 error flag", 64'(ch_err), 1);
    chk(cnt_r == 0, "R10 no refill", 64'(cnt_r), 0);

    // R11: extraction checks
    clear_logs();
    put_dcb(0, 64'h1, 16'h100, 1);
    m[3] = 64'h2004;
    add_ex(0, 0, 0); add_ex(8, 0, 0); add_ex(24, 0, 0);
    start(64'h0, 1, 1);
    wait_idle();
    compare("R11 misaligned block");
    chk(ch_err == 1, "R11 misaligned block error", 64'(ch_err), 1);

    clear_logs();
    put_dcb(0, 64'h1, 16'h0C0, 1);
    add_ex(0, 0, 0); add_ex(8, 0, 0); add_ex(24, 0, 0);
    start(64'h0, 1, 1);
    wait_idle();
    compare("R11 short length");
    chk(ch_err == 1, "R11 length error", 64'(ch_err), 1);

    clear_logs();
    put_dcb(0, 64'h1, 16'h0C0, 1);
    m[3] = 64'h2004;
    add_ex(0, 0, 0); add_ex(8, 0, 0);
    exp_blk(0, 0, 64'h2004, 16'h0C0);
    start(64'h0, 1, 0);
    wait_idle();
    compare("R11 injection unchecked");
    chk(ch_err == 0, "R11 injection no error", 64'(ch_err), 0);

    clear_logs();
    put_dcb(0, 64'h1, 16'h180, 1);
    exp_dcb(0, 1, 16'h180);
    start(64'h0, 1, 1);
    wait_idle();
    compare("R11 legal extraction");
    chk(ch_err == 0 && cnt_r == 1, "R11 legal extraction completes", 64'(ch_err), 0);

    pulse_stop();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule